// File: doc/BRIEF.md
# Bit-Serial Rank Selector

This block picks the r-th largest value out of a window of COUNT unsigned samples, each WIDTH bits wide. A rank of 1 gives the maximum, a rank of COUNT gives the minimum, and a rank of (COUNT+1)/2 gives the median for an odd COUNT. The window is captured in parallel when `start` is accepted. It is then held as WIDTH bit-plane registers of COUNT bits each, so plane j gathers bit j of every sample. Each clock examines one plane, starting with the most significant, across all samples at once.

A COUNT-bit candidate mask starts with every bit set. On each plane the block counts how many candidates carry a 1. If that count reaches the remaining rank, the result bit is 1 and candidates showing 0 are dropped. Otherwise the result bit is 0, the count is taken off the remaining rank, and candidates showing 1 are dropped. The samples are never sorted, exchanged or overwritten. The plane ring rotates once per plane and comes back to its loaded contents at the end, so a later run can reuse the stored window.

The result bits come out serially, most significant bit first, while the scan runs. The assembled word is registered one cycle later together with a one-cycle `done` pulse. This happens WIDTH+1 cycles after the start edge, whatever COUNT is. The controller has three states: IDLE, SCAN and FINISH. Its transitions are IDLE→SCAN on an accepted start, SCAN→SCAN while planes remain, SCAN→FINISH after the least significant plane, and FINISH→IDLE unconditionally. The `rank_sel` input must lie in 1..COUNT when `start` is accepted.

Top module: `rank_select_serial`

## Requirements
- R1: When `done` is high, `result` equals the `rank_sel`-th largest of the COUNT unsigned samples. Sample i sits at `win_data[i*WIDTH +: WIDTH]`. Equal values count once per occurrence, so rank 1 gives the maximum and rank COUNT gives the minimum.
- R2: `done` is high for exactly one cycle. It is high in the cycle that follows the (WIDTH+1)-th rising edge after the edge that accepted `start`. `result` holds its value until the next `done`.
- R3: During the WIDTH cycles that directly follow the accepting edge, `res_vld` is 1 and `res_bit` carries the result bits from the most significant down to the least significant. At all other times `res_vld` is 0.
- R4: A `start` raised while `busy` is 1 is ignored. The running selection keeps its window, its rank and its timing.
- R5: A start accepted with `keep_win` = 1 runs on the window stored by the previous load and ignores `win_data`. The selection therefore leaves the stored samples unchanged.
- R6: After reset, `busy`, `done` and `res_vld` are 0 and `result` is 0.
- R7: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a selection; accepted only while idle |
| keep_win | input | 1 | With start: reuse the stored window instead of loading `win_data` |
| win_data | input | COUNT*WIDTH | Parallel window, sample i at bits i*WIDTH +: WIDTH |
| rank_sel | input | $clog2(COUNT+1) | Rank to select, 1 = largest, COUNT = smallest |
| busy | output | 1 | A selection is in progress |
| res_bit | output | 1 | Serial result bit, MSB first |
| res_vld | output | 1 | `res_bit` is meaningful this cycle |
| result | output | WIDTH | Assembled result, held until the next one |
| done | output | 1 | One-cycle pulse marking a fresh `result` |

## Verification
The bench aims at windows where every sample is equal and at windows with many duplicates. A counting rule that mishandles ties drops the wrong candidates there and returns a value that is not in the window. It drives rank 1 and rank COUNT, where an off-by-one in the comparison against the remaining rank selects a neighbouring value. It also pulses `start` in the middle of a scan, which would corrupt the answer or shift `done` if the pulse were not ignored. Finally, it re-runs on a kept window with new ranks. A ring that did not return to its loaded contents would give wrong answers on that second pass.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SCAN   = 2'd1,
        S_FINISH = 2'd2
    } rsel_state_e;
endpackage

// File: rtl/rsel_plane_ring.sv
// Bit-plane storage: plane j holds bit j of every sample. Rotates one plane
// per scan cycle so the MSB plane is always at the top; WIDTH rotations
// restore the loaded order.
module rsel_plane_ring #(
    parameter int WIDTH = 8,
    parameter int COUNT = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   rotate,
    input  logic [COUNT*WIDTH-1:0] win_data,
    output logic [COUNT-1:0]       top_plane
);
    logic [COUNT-1:0] ring  [WIDTH];
    logic [COUNT-1:0] fresh [WIDTH];

    for (genvar j = 0; j < WIDTH; j++) begin : g_plane
        for (genvar i = 0; i < COUNT; i++) begin : g_sample
            assign fresh[j][i] = win_data[i*WIDTH + j];
        end

        if (j == 0) begin : g_wrap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ring[j] <= '0;
                else if (load)   ring[j] <= fresh[j];
                else if (rotate) ring[j] <= ring[WIDTH-1];
            end
        end else begin : g_link
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ring[j] <= '0;
                else if (load)   ring[j] <= fresh[j];
                else if (rotate) ring[j] <= ring[j-1];
            end
        end
    end

    assign top_plane = ring[WIDTH-1];
endmodule

// File: rtl/rsel_popcount.sv
module rsel_popcount #(
    parameter int COUNT = 9,
    parameter int CW    = $clog2(COUNT+1)
) (
    input  logic [COUNT-1:0] vec,
    output logic [CW-1:0]    ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < COUNT; i++) ones = ones + CW'(vec[i]);
    end
endmodule

// File: rtl/rsel_decide.sv
// One elimination step on a single bit plane.
module rsel_decide #(
    parameter int COUNT = 9,
    parameter int CW    = $clog2(COUNT+1)
) (
    input  logic [COUNT-1:0] mask,
    input  logic [COUNT-1:0] plane,
    input  logic [CW-1:0]    remaining,
    output logic             bit_one,
    output logic [COUNT-1:0] next_mask,
    output logic [CW-1:0]    next_rem
);
    logic [CW-1:0] ones;

    rsel_popcount #(.COUNT(COUNT), .CW(CW)) u_pop (
        .vec  (mask & plane),
        .ones (ones)
    );

    always_comb begin
        bit_one = (ones >= remaining);
        if (bit_one) begin
            next_mask = mask & plane;
            next_rem  = remaining;
        end else begin
            next_mask = mask & ~plane;
            next_rem  = remaining - ones;
        end
    end
endmodule

// File: rtl/rank_select_serial.sv
module rank_select_serial #(
    parameter  int WIDTH = 8,
    parameter  int COUNT = 9,
    localparam int CW    = $clog2(COUNT+1),
    localparam int PW    = $clog2(WIDTH+1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   keep_win,
    input  logic [COUNT*WIDTH-1:0] win_data,
    input  logic [CW-1:0]          rank_sel,
    output logic                   busy,
    output logic                   res_bit,
    output logic                   res_vld,
    output logic [WIDTH-1:0]       result,
    output logic                   done
);
    import rsel_pkg::*;

    rsel_state_e      state, state_nx;
    logic [PW-1:0]    plane_left;
    logic [COUNT-1:0] cand_mask;
    logic [CW-1:0]    rem_rank;
    logic [WIDTH-1:0] accum;
    logic [WIDTH-1:0] result_q;
    logic             done_q;

    logic             accept;
    logic             last_plane;
    logic [COUNT-1:0] top_plane;
    logic             bit_one;
    logic [COUNT-1:0] next_mask;
    logic [CW-1:0]    next_rem;

    assign accept     = (state == S_IDLE) && start;
    assign last_plane = (plane_left == '0);

    rsel_plane_ring #(.WIDTH(WIDTH), .COUNT(COUNT)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && !keep_win),
        .rotate    (state == S_SCAN),
        .win_data  (win_data),
        .top_plane (top_plane)
    );

    rsel_decide #(.COUNT(COUNT), .CW(CW)) u_decide (
        .mask      (cand_mask),
        .plane     (top_plane),
        .remaining (rem_rank),
        .bit_one   (bit_one),
        .next_mask (next_mask),
        .next_rem  (next_rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_SCAN;
            S_SCAN:   if (last_plane) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Scan datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane_left <= '0;
            cand_mask  <= '0;
            rem_rank   <= '0;
            accum      <= '0;
            result_q   <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    plane_left <= PW'(WIDTH-1);
                    cand_mask  <= '1;
                    rem_rank   <= rank_sel;
                    accum      <= '0;
                end
                S_SCAN: begin
                    plane_left <= plane_left - 1'b1;
                    cand_mask  <= next_mask;
                    rem_rank   <= next_rem;
                    accum      <= (accum << 1) | WIDTH'(bit_one);
                end
                S_FINISH: begin
                    result_q <= accum;
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (state != S_IDLE);
        res_vld = (state == S_SCAN);
        res_bit = res_vld && bit_one;
        result  = result_q;
        done    = done_q;
    end
endmodule

// File: rtl/rsel_checker.sv
module rsel_checker #(
    parameter int WIDTH = 8,
    parameter int COUNT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             res_bit,
    input logic             res_vld,
    input logic [WIDTH-1:0] result,
    input logic [COUNT-1:0] cand_mask
);
    localparam int TW = $clog2(WIDTH+3);
    logic [TW-1:0] busy_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cyc <= '0;
        else if (busy) busy_cyc <= busy_cyc + 1'b1;
        else           busy_cyc <= '0;
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cyc == TW'(WIDTH+1)));

    p_lsb_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(res_vld, 2) && result[0] == $past(res_bit, 2)));

    p_vld_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> busy);

    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_mask_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (cand_mask != '0));
endmodule

bind rank_select_serial rsel_checker #(.WIDTH(WIDTH), .COUNT(COUNT)) u_rsel_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .res_bit   (res_bit),
    .res_vld   (res_vld),
    .result    (result),
    .cand_mask (cand_mask)
);

// File: tb/rank_select_serial_bench.sv
module rank_select_serial_bench;
    localparam int WIDTH    = 8;
    localparam int COUNT    = 9;
    localparam int CW       = $clog2(COUNT+1);
    localparam int CLK_HALF = 5;
    localparam int NVEC     = 7;

    localparam logic [WIDTH-1:0] TBL_S [NVEC][COUNT] = '{
        '{8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80, 8'd90},
        '{8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80, 8'd90},
        '{8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80, 8'd90},
        '{8'd7,  8'd7,  8'd7,  8'd7,  8'd7,  8'd7,  8'd7,  8'd7,  8'd7},
        '{8'd255,8'd0,  8'd255,8'd0,  8'd128,8'd128,8'd3,  8'd3,  8'd3},
        '{8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
        '{8'd5,  8'd200,8'd5,  8'd200,8'd5,  8'd1,  8'd1,  8'd1,  8'd255}
    };
    localparam int TBL_R [NVEC] = '{5, 1, 9, 3, 6, 9, 2};
    localparam logic [WIDTH-1:0] TBL_E [NVEC] =
        '{8'd50, 8'd90, 8'd10, 8'd7, 8'd3, 8'd0, 8'd200};

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic                   keep_win = 1'b0;
    logic [COUNT*WIDTH-1:0] win_data = '0;
    logic [CW-1:0]          rank_sel = '0;
    logic                   busy, res_bit, res_vld, done;
    logic [WIDTH-1:0]       result;

    int tests = 0;
    int fails = 0;

    always #CLK_HALF clk = ~clk;

    rank_select_serial #(.WIDTH(WIDTH), .COUNT(COUNT)) u_rank_select_serial (
        .clk(clk), .rst_n(rst_n), .start(start), .keep_win(keep_win),
        .win_data(win_data), .rank_sel(rank_sel), .busy(busy),
        .res_bit(res_bit), .res_vld(res_vld), .result(result), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] ref_rank(input logic [COUNT*WIDTH-1:0] w, input int r);
        logic [WIDTH-1:0] v;
        ref_rank = '0;
        for (int i = 0; i < COUNT; i++) begin
            int gt = 0;
            int ge = 0;
            v = w[i*WIDTH +: WIDTH];
            for (int j = 0; j < COUNT; j++) begin
                if (w[j*WIDTH +: WIDTH] > v)  gt++;
                if (w[j*WIDTH +: WIDTH] >= v) ge++;
            end
            if (gt < r && r <= ge) ref_rank = v;
        end
    endfunction

    // One full selection; poke raises start in the middle of the scan (R4).
    task automatic run_sel(input logic [COUNT*WIDTH-1:0] w, input int r, input logic keep,
                           input logic [WIDTH-1:0] exp, input logic poke);
        logic [WIDTH-1:0] sbits;
        int vld_miss;
        vld_miss = 0;
        sbits = '0;
        @(negedge clk);
        win_data = w; rank_sel = CW'(r); keep_win = keep; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", busy, 1);
        for (int b = WIDTH-1; b >= 0; b--) begin
            if (!res_vld) vld_miss++;
            sbits[b] = res_bit;
            if (poke && b == WIDTH/2) begin
                start = 1'b1; win_data = ~w; rank_sel = CW'(1); keep_win = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk("R3 res_vld during scan", vld_miss, 0);
        chk("R3 res_vld low after scan", res_vld, 0);
        chk("R2 done not early", done, 0);
        @(negedge clk);
        chk("R2 done at WIDTH+1", done, 1);
        chk(poke ? "R4 result after ignored start" : "R1 result", result, exp);
        chk("R3 serial bits", sbits, exp);
        chk("R7 busy low at done", busy, 0);
        @(negedge clk);
        chk("R2 done one cycle", done, 0);
        chk("R2 result held", result, exp);
        win_data = w;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [COUNT*WIDTH-1:0] w;
        repeat (3) @(negedge clk);
        chk("R6 busy reset", busy, 0);
        chk("R6 done reset", done, 0);
        chk("R6 res_vld reset", res_vld, 0);
        chk("R6 result reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk (R1: mid rank, rank 1, rank COUNT, all-equal, duplicates)
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < COUNT; i++) w[i*WIDTH +: WIDTH] = TBL_S[v][i];
            run_sel(w, TBL_R[v], 1'b0, TBL_E[v], 1'b0);
        end

        // R4: start raised mid-scan is ignored
        for (int i = 0; i < COUNT; i++) w[i*WIDTH +: WIDTH] = TBL_S[0][i];
        run_sel(w, 5, 1'b0, 8'd50, 1'b1);

        // R5: reuse stored window, win_data garbage
        run_sel(w, 5, 1'b0, 8'd50, 1'b0);
        run_sel(~w, 1, 1'b1, 8'd90, 1'b0);
        run_sel('0, 9, 1'b1, 8'd10, 1'b0);
        run_sel({COUNT*WIDTH{1'b1}}, 3, 1'b1, 8'd70, 1'b0);

        // R1: random windows against a software reference
        for (int n = 0; n < 40; n++) begin
            int r;
            for (int i = 0; i < COUNT; i++)
                w[i*WIDTH +: WIDTH] = (n % 4 == 0) ? WIDTH'($urandom_range(0, 3))
                                                    : WIDTH'($urandom);
            r = (n % 5 == 0) ? 1 : (n % 5 == 1) ? COUNT : int'($urandom_range(1, COUNT));
            run_sel(w, r, 1'b0, ref_rank(w, r), 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule